// File: doc/BRIEF.md
# Dilated Circuit-Switched Crossbar Router

This block is one switching element of a circuit-switched network. It has several forward ports, where sources open connections. It also has several backward ports, which lead onward to the next stage. The backward ports are split into logical directions. Each direction is a group of `DIL` equivalent ports, so a connection may use any one of them. Every word on a port is `W+1` bits wide: a tag bit and a `W`-bit payload. The tag separates data words from signal words.

A source opens a circuit by presenting a data word on an idle forward port. The low bits of that word name the direction. The router strips those bits and forwards the rest of the word on a backward port of that direction. The port is a free one, chosen with a pseudo-random starting offset. When several sources ask for one direction in the same cycle, a rotating-priority arbiter for that direction picks one winner. A source that loses, or finds every port of its direction busy, gets a blocked status word back and may retry. An open circuit owns its backward port until a drop word closes it. A turn word reverses the circuit, so words coming back from the destination flow to the source.

Top module: `xbar_router`

## Requirements
- R1: While `rst_n` is low at a clock edge, every `fwd_out` and `bwd_out` word becomes NULL after that edge, every forward port returns to idle, every backward port becomes free and every arbiter pointer returns to 0.
- R2: Bit `W` of a word is the tag: 0 means data, 1 means signal. Signal payload codes are NULL=0, DROP=1, TURN=2 and BLOCK=3. An output that has nothing to carry shows NULL.
- R3: A data word on an idle forward port starts a route. Its low log2(`N_DIR`) bits select direction d, which owns backward ports d·`DIL` to d·`DIL`+`DIL`−1. Two clock edges after that word, the granted port outputs a data word carrying the payload shifted right by log2(`N_DIR`), with the vacated upper bits set to zero.
- R4: A grant goes only to a backward port that was free in the direction requested. A backward port belongs to at most one forward port at a time.
- R5: Each direction grants at most one new circuit per cycle. The winner is the first requester at or after that direction's pointer, counting upward with wrap-around. The pointer then moves to the winner + 1, wrapping at `N_IN`.
- R6: A routing port that loses arbitration, or whose direction has no free port, holds no backward port. It outputs one BLOCK word on `fwd_out` at the edge where a grant would have appeared. It then stays blocked, ignoring everything except DROP.
- R7: In the forward state, every word on `fwd_in` appears on the owned backward port one edge later.
- R8: A DROP in the forward state is passed downstream and returns the forward port to idle. The backward port it held is free for requests evaluated in the next cycle, but not for requests evaluated in the same cycle as the drop.
- R9: A TURN in the forward state is passed downstream, and the circuit reverses. After that, `bwd_in` of the owned port appears on `fwd_out` one edge later, and data on `fwd_in` is not forwarded. The circuit closes on a DROP from the source, which is passed downstream, or on a DROP from the destination, which is passed upstream.
- R10: Signal words on an idle forward port are ignored: the port stays idle and its `fwd_out` stays NULL.
- R11: A DROP on a forward port that is waiting for its grant returns it to idle. No grant is made and no BLOCK word is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fwd_in | input | N_IN*(W+1) | Words from the sources, one per forward port |
| fwd_out | output | N_IN*(W+1) | Words returned to the sources (blocked status, reversed data) |
| bwd_out | output | N_DIR*DIL*(W+1) | Words sent toward the destinations, one per backward port |
| bwd_in | input | N_DIR*DIL*(W+1) | Words returned by the destinations on each backward port |

## Verification
Closing a circuit and granting a new request for the same direction can fall in the same cycle. The bench provokes this by sending a DROP on one forward port while another port is being arbitrated for a direction whose only remaining free port is the one being dropped. The expected outcome is a BLOCK word, not a grant. The bench also lets three ports request one direction in a single cycle, so that one winner and two blocked ports must appear together, and it judges the winner against a rotating pointer kept in its own model. Because the port choice is pseudo-random, the model accepts any backward port that it holds as free in the requested direction, then follows that port for the rest of the circuit.

// File: rtl/xbar_router_pkg.sv
// Shared encodings for the dilated crossbar router.
// Assumes the signal code fits in the payload (W >= 2).
package xbar_router_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ROUTE = 3'd1,
        ST_FWD   = 3'd2,
        ST_REV   = 3'd3,
        ST_BLK   = 3'd4
    } fport_state_t;

    localparam int unsigned CODE_NULL  = 0;
    localparam int unsigned CODE_DROP  = 1;
    localparam int unsigned CODE_TURN  = 2;
    localparam int unsigned CODE_BLOCK = 3;
endpackage

// File: rtl/xr_lfsr.sv
// Free-running Galois LFSR that supplies the pseudo-random offset for port choice.
// Assumes SEED is non-zero; it runs on every clock out of reset.
module xr_lfsr #(
    parameter int unsigned          WIDTH = 16,
    parameter logic [WIDTH-1:0]     TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0]     SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state
);
    // Advance the shift register one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        state <= SEED;
        else if (state[0]) state <= (state >> 1) ^ TAPS;
        else               state <= state >> 1;
    end
endmodule

// File: rtl/xr_rr_arbiter.sv
// Rotating-priority arbiter for one logical direction. The winner is the first
// requester at or after the pointer. The pointer moves past the winner only when
// a grant is actually issued (enable high).
module xr_rr_arbiter #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         enable,
    output logic [N-1:0] grant
);
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic          found;

    // Search the requests upward from the pointer, with wrap-around.
    always_comb begin
        int idx;
        found = 1'b0;
        win   = '0;
        grant = '0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= int'(N)) idx = idx - int'(N);
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = IW'(idx);
            end
        end
        if (found && enable) grant[win] = 1'b1;
    end

    // Move the pointer to the position after the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)               ptr <= '0;
        else if (found && enable) ptr <= (int'(win) == int'(N) - 1) ? '0 : win + IW'(1);
    end
endmodule

// File: rtl/xr_free_pick.sv
// Picks one free port from a dilated group, starting the search at an offset
// taken from the random word (shifted by SHIFT so directions differ).
// Assumes DIL >= 2.
module xr_free_pick #(
    parameter int unsigned DIL   = 2,
    parameter int unsigned SHIFT = 0
) (
    input  logic [DIL-1:0]         free,
    input  logic [15:0]            rnd,
    output logic                   valid,
    output logic [$clog2(DIL)-1:0] idx
);
    localparam int unsigned OB = $clog2(DIL);

    logic [15:0]   sh;
    logic [OB-1:0] off;

    // Form a legal starting offset from the random bits.
    always_comb begin
        sh  = rnd >> SHIFT;
        off = sh[OB-1:0];
        if (int'(off) >= int'(DIL)) off = '0;
    end

    // Take the first free port at or after the offset.
    always_comb begin
        int p;
        valid = 1'b0;
        idx   = '0;
        for (int k = 0; k < DIL; k++) begin
            p = int'(off) + k;
            if (p >= int'(DIL)) p = p - int'(DIL);
            if (!valid && free[p]) begin
                valid = 1'b1;
                idx   = OB'(p);
            end
        end
    end
endmodule

// File: rtl/xbar_router.sv
// Dilated circuit-switched crossbar. Each forward port runs its own connection
// state machine. Each backward port keeps a busy flag and is written only by its
// owner. Every output is registered. Assumes N_DIR is a power of two, N_DIR >= 2
// and DIL >= 2.
module xbar_router
    import xbar_router_pkg::*;
#(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned N_DIR = 2,
    parameter int unsigned DIL   = 2,
    parameter int unsigned W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_IN-1:0][W:0]        fwd_in,
    output logic [N_IN-1:0][W:0]        fwd_out,
    output logic [N_DIR*DIL-1:0][W:0]   bwd_out,
    input  logic [N_DIR*DIL-1:0][W:0]   bwd_in
);
    localparam int unsigned N_OUT = N_DIR * DIL;
    localparam int unsigned DIRB  = $clog2(N_DIR);
    localparam int unsigned PB    = $clog2(N_OUT);
    localparam int unsigned OB    = $clog2(DIL);
    localparam logic [W:0]  WD_NULL  = {1'b1, W'(CODE_NULL)};
    localparam logic [W:0]  WD_DROP  = {1'b1, W'(CODE_DROP)};
    localparam logic [W:0]  WD_TURN  = {1'b1, W'(CODE_TURN)};
    localparam logic [W:0]  WD_BLOCK = {1'b1, W'(CODE_BLOCK)};

    fport_state_t [N_IN-1:0]           st;
    logic [N_IN-1:0][DIRB-1:0]         hdir;
    logic [N_IN-1:0][W-1:0]            hpay;
    logic [N_IN-1:0][PB-1:0]           conn;
    logic [N_OUT-1:0]                  busy;
    logic [N_IN-1:0]                   drop_in;
    logic [N_DIR-1:0][N_IN-1:0]        gnt;
    logic [N_DIR-1:0]                  pval;
    logic [N_DIR-1:0][OB-1:0]          pidx;
    logic [N_IN-1:0]                   grant_in;
    logic [N_IN-1:0][PB-1:0]           gport;
    logic [15:0]                       rnd;

    xr_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd));

    // Flag the drop words arriving on each forward port.
    always_comb begin
        for (int i = 0; i < N_IN; i++) drop_in[i] = (fwd_in[i] == WD_DROP);
    end

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        logic [N_IN-1:0] req;

        // Collect the routing requests aimed at this direction.
        always_comb begin
            for (int i = 0; i < N_IN; i++)
                req[i] = (st[i] == ST_ROUTE) && (hdir[i] == DIRB'(d)) && !drop_in[i];
        end

        xr_free_pick #(.DIL(DIL), .SHIFT(d)) u_pick (
            .free  (~busy[d*DIL +: DIL]),
            .rnd   (rnd),
            .valid (pval[d]),
            .idx   (pidx[d])
        );

        xr_rr_arbiter #(.N(N_IN)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req),
            .enable (pval[d]),
            .grant  (gnt[d])
        );
    end

    // Map each direction's grant back to its forward port and physical port.
    always_comb begin
        grant_in = '0;
        gport    = '0;
        for (int d = 0; d < N_DIR; d++) begin
            for (int i = 0; i < N_IN; i++) begin
                if (gnt[d][i]) begin
                    grant_in[i] = 1'b1;
                    gport[i]    = PB'(d * DIL) + PB'(pidx[d]);
                end
            end
        end
    end

    // Connection state machines, busy flags and registered crossbar outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= {N_IN{ST_IDLE}};
            hdir    <= '0;
            hpay    <= '0;
            conn    <= '0;
            busy    <= '0;
            fwd_out <= {N_IN{WD_NULL}};
            bwd_out <= {N_OUT{WD_NULL}};
        end else begin
            fwd_out <= {N_IN{WD_NULL}};
            bwd_out <= {N_OUT{WD_NULL}};
            for (int i = 0; i < N_IN; i++) begin
                case (st[i])
                    ST_IDLE: begin
                        if (!fwd_in[i][W]) begin
                            hdir[i] <= fwd_in[i][DIRB-1:0];
                            hpay[i] <= fwd_in[i][W-1:0] >> DIRB;
                            st[i]   <= ST_ROUTE;
                        end
                    end
                    ST_ROUTE: begin
                        if (drop_in[i]) begin
                            st[i] <= ST_IDLE;
                        end else if (grant_in[i]) begin
                            conn[i]           <= gport[i];
                            busy[gport[i]]    <= 1'b1;
                            bwd_out[gport[i]] <= {1'b0, hpay[i]};
                            st[i]             <= ST_FWD;
                        end else begin
                            fwd_out[i] <= WD_BLOCK;
                            st[i]      <= ST_BLK;
                        end
                    end
                    ST_FWD: begin
                        bwd_out[conn[i]] <= fwd_in[i];
                        if (drop_in[i]) begin
                            busy[conn[i]] <= 1'b0;
                            st[i]         <= ST_IDLE;
                        end else if (fwd_in[i] == WD_TURN) begin
                            st[i] <= ST_REV;
                        end
                    end
                    ST_REV: begin
                        fwd_out[i] <= bwd_in[conn[i]];
                        if (drop_in[i]) begin
                            bwd_out[conn[i]] <= WD_DROP;
                            busy[conn[i]]    <= 1'b0;
                            st[i]            <= ST_IDLE;
                        end else if (bwd_in[conn[i]] == WD_DROP) begin
                            busy[conn[i]] <= 1'b0;
                            st[i]         <= ST_IDLE;
                        end
                    end
                    ST_BLK: begin
                        if (drop_in[i]) st[i] <= ST_IDLE;
                    end
                    default: st[i] <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/xbar_router_chk.sv
// Assertion checker for the dilated crossbar router, attached through bind.
// It observes the state machines, busy flags and arbiter grants.
module xbar_router_chk
    import xbar_router_pkg::*;
#(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned N_DIR = 2,
    parameter int unsigned DIL   = 2,
    parameter int unsigned W     = 8
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic [N_IN-1:0][W:0]                   fwd_in,
    input logic [N_IN-1:0][W:0]                   fwd_out,
    input logic [N_DIR*DIL-1:0][W:0]              bwd_out,
    input fport_state_t [N_IN-1:0]                st,
    input logic [N_IN-1:0][$clog2(N_DIR*DIL)-1:0] conn,
    input logic [N_DIR*DIL-1:0]                   busy,
    input logic [N_DIR-1:0][N_IN-1:0]             gnt,
    input logic [N_IN-1:0]                        grant_in,
    input logic [N_IN-1:0][$clog2(N_DIR*DIL)-1:0] gport,
    input logic [N_IN-1:0]                        drop_in
);
    localparam logic [W:0] WD_DROP  = {1'b1, W'(CODE_DROP)};
    localparam logic [W:0] WD_BLOCK = {1'b1, W'(CODE_BLOCK)};

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir_chk
        a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(gnt[d]) <= 1);
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in_chk
        a_r4_port_was_free: assert property (@(posedge clk) disable iff (!rst_n)
            grant_in[i] |-> !busy[gport[i]]);
        a_r6_loser_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == ST_ROUTE && !drop_in[i] && !grant_in[i])
            |=> (fwd_out[i] == WD_BLOCK && st[i] == ST_BLK));
        a_r7_stream_forward: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == ST_FWD) |=> (bwd_out[$past(conn[i])] == $past(fwd_in[i])));
        a_r8_drop_frees: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == ST_FWD && fwd_in[i] == WD_DROP)
            |=> (st[i] == ST_IDLE && !busy[$past(conn[i])]));
        a_r11_route_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (st[i] == ST_ROUTE && drop_in[i]) |=> (st[i] == ST_IDLE));
    end

    // R4: no two live circuits share a backward port.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int a = 0; a < N_IN; a++)
                for (int b = a + 1; b < N_IN; b++)
                    if ((st[a] == ST_FWD || st[a] == ST_REV) && (st[b] == ST_FWD || st[b] == ST_REV))
                        a_r4_exclusive: assert (conn[a] != conn[b]);
        end
    end
endmodule

bind xbar_router xbar_router_chk #(
    .N_IN(N_IN), .N_DIR(N_DIR), .DIL(DIL), .W(W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_in   (fwd_in),
    .fwd_out  (fwd_out),
    .bwd_out  (bwd_out),
    .st       (st),
    .conn     (conn),
    .busy     (busy),
    .gnt      (gnt),
    .grant_in (grant_in),
    .gport    (gport),
    .drop_in  (drop_in)
);

// File: tb/xbar_router_bench.sv
// Cycle-by-cycle reference model of the router, compared on every clock.
module xbar_router_bench;
    localparam int N_IN = 4, N_DIR = 2, DIL = 2, W = 8, N_OUT = N_DIR * DIL;
    localparam int S_IDLE = 0, S_ROUTE = 1, S_FWD = 2, S_REV = 3, S_BLK = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [N_IN-1:0][W:0]  fwd_in, fwd_out;
    logic [N_OUT-1:0][W:0] bwd_out, bwd_in;

    xbar_router #(.N_IN(N_IN), .N_DIR(N_DIR), .DIL(DIL), .W(W)) u_xbar_router (
        .clk(clk), .rst_n(rst_n), .fwd_in(fwd_in), .fwd_out(fwd_out),
        .bwd_out(bwd_out), .bwd_in(bwd_in)
    );

    int checks = 0, errors = 0, cnt = 0;
    int m_st[N_IN], m_dir[N_IN], m_pay[N_IN], m_conn[N_IN];
    int m_busy[N_OUT], m_ptr[N_DIR];
    logic [W:0] e_fo[N_IN], e_bo[N_OUT];
    string t_fo[N_IN], t_bo[N_OUT];
    logic [W:0] ovr[N_OUT];
    bit ovr_en[N_OUT];

    function automatic logic [W:0] sg(int c); return {1'b1, 8'(c)}; endfunction
    function automatic logic [W:0] dt(int v); return {1'b0, 8'(v)}; endfunction

    task automatic check(string tag, string what, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(logic [N_IN-1:0][W:0] fi, logic [N_OUT-1:0][W:0] bi);
        int busy_old[N_OUT];
        int gp[N_IN];
        busy_old = m_busy;
        for (int i = 0; i < N_IN; i++) begin gp[i] = -1; e_fo[i] = sg(0); t_fo[i] = "R2"; end
        for (int p = 0; p < N_OUT; p++) begin e_bo[p] = sg(0); t_bo[p] = "R2"; end
        // R5: rotating choice of one winner per direction
        for (int d = 0; d < N_DIR; d++) begin
            int winner = -1;
            bit anyfree = 0;
            for (int k = 0; k < N_IN; k++) begin
                int idx = (m_ptr[d] + k) % N_IN;
                if (winner < 0 && m_st[idx] == S_ROUTE && m_dir[idx] == d && fi[idx] != sg(1)) winner = idx;
            end
            for (int p = d * DIL; p < d * DIL + DIL; p++) if (busy_old[p] == 0) anyfree = 1;
            if (winner >= 0 && anyfree) begin
                int found = -1;
                for (int p = d * DIL; p < d * DIL + DIL; p++)
                    if (found < 0 && busy_old[p] == 0 && bwd_out[p] == dt(m_pay[winner])) found = p;
                checks++;
                if (found < 0) begin
                    errors++;
                    $display("FAIL R4 grant to input %0d: actual=no free port of dir %0d shows header expected=%h",
                             winner, d, dt(m_pay[winner]));
                    for (int p = d * DIL; p < d * DIL + DIL; p++) if (found < 0 && busy_old[p] == 0) found = p;
                end
                gp[winner] = found;
                m_ptr[d] = (winner + 1) % N_IN;
            end
        end
        for (int i = 0; i < N_IN; i++) begin
            case (m_st[i])
                S_IDLE: begin
                    t_fo[i] = "R10";
                    if (fi[i][W] == 1'b0) begin
                        m_dir[i] = int'(fi[i][W-1:0]) % N_DIR;
                        m_pay[i] = int'(fi[i][W-1:0]) / N_DIR;
                        m_st[i] = S_ROUTE;
                    end
                end
                S_ROUTE: begin
                    if (fi[i] == sg(1)) begin m_st[i] = S_IDLE; t_fo[i] = "R11"; end
                    else if (gp[i] >= 0) begin
                        m_conn[i] = gp[i]; m_busy[gp[i]] = 1;
                        e_bo[gp[i]] = dt(m_pay[i]); t_bo[gp[i]] = "R3 R5";
                        m_st[i] = S_FWD;
                    end else begin
                        e_fo[i] = sg(3); t_fo[i] = "R6"; m_st[i] = S_BLK;
                    end
                end
                S_FWD: begin
                    e_bo[m_conn[i]] = fi[i]; t_bo[m_conn[i]] = "R7";
                    if (fi[i] == sg(1)) begin
                        m_busy[m_conn[i]] = 0; m_st[i] = S_IDLE; t_bo[m_conn[i]] = "R8";
                    end else if (fi[i] == sg(2)) begin
                        m_st[i] = S_REV; t_bo[m_conn[i]] = "R9";
                    end
                end
                S_REV: begin
                    e_fo[i] = bi[m_conn[i]]; t_fo[i] = "R9"; t_bo[m_conn[i]] = "R9";
                    if (fi[i] == sg(1)) begin
                        e_bo[m_conn[i]] = sg(1); m_busy[m_conn[i]] = 0; m_st[i] = S_IDLE;
                    end else if (bi[m_conn[i]] == sg(1)) begin
                        m_busy[m_conn[i]] = 0; m_st[i] = S_IDLE;
                    end
                end
                default: begin
                    t_fo[i] = "R6";
                    if (fi[i] == sg(1)) m_st[i] = S_IDLE;
                end
            endcase
        end
    endtask

    // One clock: apply inputs, step the model after the edge and compare all outputs.
    task automatic cyc();
        logic [N_IN-1:0][W:0]  fi;
        logic [N_OUT-1:0][W:0] bi;
        for (int p = 0; p < N_OUT; p++) bwd_in[p] = ovr_en[p] ? ovr[p] : dt((p * 37 + cnt) & 255);
        #0;
        fi = fwd_in; bi = bwd_in;
        @(posedge clk); #1;
        cnt++;
        model_step(fi, bi);
        for (int i = 0; i < N_IN; i++) check(t_fo[i], $sformatf("fwd_out[%0d]", i), fwd_out[i], e_fo[i]);
        for (int p = 0; p < N_OUT; p++) check(t_bo[p], $sformatf("bwd_out[%0d]", p), bwd_out[p], e_bo[p]);
        for (int i = 0; i < N_IN; i++) fwd_in[i] = sg(0);
        for (int p = 0; p < N_OUT; p++) ovr_en[p] = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < N_IN; i++) begin fwd_in[i] = sg(0); m_st[i] = S_IDLE; m_dir[i] = 0; m_pay[i] = 0; m_conn[i] = 0; end
        for (int p = 0; p < N_OUT; p++) begin bwd_in[p] = sg(0); m_busy[p] = 0; ovr_en[p] = 0; ovr[p] = sg(0); end
        for (int d = 0; d < N_DIR; d++) m_ptr[d] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state at the ports
        for (int i = 0; i < N_IN; i++) check("R1", $sformatf("reset fwd_out[%0d]", i), fwd_out[i], sg(0));
        for (int p = 0; p < N_OUT; p++) check("R1", $sformatf("reset bwd_out[%0d]", p), bwd_out[p], sg(0));
        rst_n = 1'b1;
        // R10: signal words on idle ports are ignored
        fwd_in[0] = sg(2); fwd_in[1] = sg(1); fwd_in[2] = sg(3); cyc(); cyc();
        // R3 R7 R9: open on dir0, stream, turn, reverse, ignore data, close from source
        fwd_in[0] = dt(8'hA4); cyc(); cyc();
        fwd_in[0] = dt(11); cyc(); fwd_in[0] = dt(22); cyc();
        fwd_in[0] = sg(2); cyc(); cyc(); cyc();
        fwd_in[0] = dt(99); cyc();
        fwd_in[0] = sg(1); cyc(); cyc();
        // R5 R6: three requests for dir1 in one cycle
        fwd_in[1] = dt(8'h31); fwd_in[2] = dt(8'h45); fwd_in[3] = dt(8'h57); cyc(); cyc();
        fwd_in[1] = dt(5); fwd_in[2] = dt(6); cyc();
        fwd_in[2] = sg(1); fwd_in[3] = sg(1); cyc();
        fwd_in[2] = dt(3); fwd_in[3] = dt(5); cyc(); cyc();
        // R6: dir1 full, retry is blocked
        fwd_in[3] = sg(1); cyc(); fwd_in[3] = dt(7); cyc(); cyc();
        // R8: drop and request for the same direction in one cycle
        fwd_in[3] = sg(1); cyc(); fwd_in[3] = dt(9); cyc();
        fwd_in[1] = sg(1); cyc();
        fwd_in[3] = sg(1); cyc(); fwd_in[3] = dt(9); cyc(); cyc();
        fwd_in[3] = dt(8'h77); cyc();
        // R11: drop while waiting for the grant
        fwd_in[0] = dt(2); cyc(); fwd_in[0] = sg(1); cyc(); cyc();
        // R9: destination closes a reversed circuit
        fwd_in[0] = dt(4); cyc(); cyc();
        fwd_in[0] = sg(2); cyc(); cyc();
        ovr_en[m_conn[0]] = 1; ovr[m_conn[0]] = sg(1); cyc(); cyc();
        // close everything
        for (int i = 0; i < N_IN; i++) fwd_in[i] = sg(1);
        cyc(); cyc();
        summary();
        $finish;
    end
endmodule